// File: doc/BRIEF.md
# Time-of-Day Counter with Trimmed Step and Snapshot Slots

This block keeps a free-running time of day made of 48-bit seconds, 32-bit nanoseconds and a 32-bit sub-nanosecond fraction. While enabled, the time advances on every clock by a programmable step (an integer nanosecond part plus a 32-bit fraction) to which a signed fractional frequency trim is added. Nanoseconds wrap at one billion and carry into the seconds.

Software drives the block through a small map of 16-bit registers. It stages a value in seven load-value words, then writes a command word with its trigger bit set. The command either loads the staged time, loads the staged fraction as the frequency trim, adds or subtracts the staged seconds and nanoseconds, or copies the current time into one of two snapshot slots. A status register reports which slots hold a snapshot, and reading the last word of a slot releases it.

Top module: `tod_counter_unit`

## Requirements
- R1: After reset the time is zero, the run bit is 0, the step is 3 ns with zero fraction, the trim is zero, the status register (address 0x02) reads 0, and the command register (address 0x01) reads 0x001C.
- R2: Bit 0 of the control register (address 0x00) enables counting; while it is 0 the time holds, and while it is 1 the time advances once per clock by the step.
- R3: Each tick adds {step_ns, step_frac} plus the sign-extended trim to {ns, frac} as one 64-bit fixed-point sum, so a fraction overflow carries into nanoseconds; step_ns is at 0x03, step fraction high/low at 0x04/0x05.
- R4: When the nanosecond sum of a tick reaches 1,000,000,000, one billion is subtracted and seconds increment by one.
- R5: A write to the command register executes the operation in bits [4:2] only when bit 0 (trigger) is 1; with bit 0 clear, or with code 7, the time, trim and slots are unchanged.
- R6: Code 0 replaces the time with the load value (0x06..0x0C: seconds high, medium, low, nanoseconds high, low, fraction high, low); the stored copy of bit 8 of the command register reads back 0 after such a write.
- R7: Code 1 loads the load-value fraction words as a signed 32-bit trim used by every later tick.
- R8: Code 2 adds and code 3 subtracts the load-value seconds and nanoseconds in one cycle, with carry or borrow across the one-billion boundary; the fraction is unchanged.
- R9: Code 4 copies the time into slot 0 if slot 0 is empty, otherwise into slot 1; status bit 0 and bit 1 flag slot 0 and slot 1 as holding data.
- R10: Slot 0 is read at 0x10..0x16 and slot 1 at 0x18..0x1E as seconds high, medium, low, nanoseconds high, low, fraction high, low; read data appears one clock after the read strobe, and reading the seventh word clears that slot's status bit.
- R11: Codes 5 and 6 have no effect on the time, trim or slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per rising edge while running |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid one clock after rd_en |

## Verification
A wrong accumulator or carry state becomes visible only through a snapshot, so the bench stops the counter, captures, and compares all seven slot words against a model after a known number of ticks; a fraction-carry error shows after a few ticks, a rollover error at the first crossing of one billion. A wrong slot-valid flag appears at the status register on the next read and as a snapshot landing in the wrong slot. A command that misdecodes shows at the next capture as a time off by the load value.

// File: rtl/tod_pkg.sv
// Shared widths, register offsets and the time-of-day record for the
// time-of-day counter. Assumes 16-bit register words throughout.
package tod_pkg;
    localparam int WORD_W   = 16;
    localparam int SEC_W    = 3 * WORD_W;
    localparam int NS_W     = 2 * WORD_W;
    localparam int FR_W     = 2 * WORD_W;
    localparam int SUM_W    = NS_W + FR_W;
    localparam int ADDR_W   = 5;
    localparam int LV_WORDS = 7;
    localparam int N_SLOTS  = 2;

    localparam logic [NS_W-1:0] NS_PER_SEC = 32'd1_000_000_000;

    // command codes carried in command register bits [4:2]
    localparam logic [2:0] OP_LOAD = 3'd0;
    localparam logic [2:0] OP_FREQ = 3'd1;
    localparam logic [2:0] OP_INC  = 3'd2;
    localparam logic [2:0] OP_DEC  = 3'd3;
    localparam logic [2:0] OP_CAPT = 3'd4;
    localparam logic [2:0] OP_NOP  = 3'd7;

    localparam int TRIG_BIT  = 0;
    localparam int OP_LSB    = 2;
    localparam int PHASE_BIT = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] A_CMD    = 5'h01;
    localparam logic [ADDR_W-1:0] A_STAT   = 5'h02;
    localparam logic [ADDR_W-1:0] A_STP_NS = 5'h03;
    localparam logic [ADDR_W-1:0] A_STP_FH = 5'h04;
    localparam logic [ADDR_W-1:0] A_STP_FL = 5'h05;
    localparam int                A_LV     = 6;
    localparam int                SLOT_BIT = 4;
    localparam logic [2:0]        LAST_WORD = 3'd6;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
        logic [FR_W-1:0]  fr;
    } tod_t;
endpackage

// File: rtl/tod_step_adder.sv
// Next time after one tick. Adds the step plus the signed trim to the
// {ns, frac} fixed-point pair and wraps nanoseconds at one billion.
// Assumes the effective step stays below one second.
module tod_step_adder
    import tod_pkg::*;
(
    input  tod_t              cur,
    input  logic [WORD_W-1:0] step_ns,
    input  logic [FR_W-1:0]   step_fr,
    input  logic [FR_W-1:0]   trim,
    output tod_t              nxt
);
    logic [SUM_W-1:0] inc;
    logic [SUM_W-1:0] acc;
    logic [NS_W-1:0]  acc_ns;
    logic             roll;

    // fixed-point sum of current time and trimmed step
    always_comb begin
        inc    = {{(SUM_W-WORD_W-FR_W){1'b0}}, step_ns, step_fr}
               + {{(SUM_W-FR_W){trim[FR_W-1]}}, trim};
        acc    = {cur.ns, cur.fr} + inc;
        acc_ns = acc[SUM_W-1:FR_W];
        roll   = (acc_ns >= NS_PER_SEC);
        nxt.fr  = acc[FR_W-1:0];
        nxt.ns  = roll ? acc_ns - NS_PER_SEC : acc_ns;
        nxt.sec = cur.sec + SEC_W'(roll);
    end
endmodule

// File: rtl/tod_adjuster.sv
// Single-cycle step of the time forward or back by a seconds and
// nanoseconds amount. Assumes both nanosecond inputs are below one billion.
module tod_adjuster
    import tod_pkg::*;
(
    input  tod_t cur,
    input  tod_t delta,
    input  logic sub,
    output tod_t nxt
);
    logic [NS_W:0]   ns_sum;
    logic            carry;
    logic            borrow;
    logic [NS_W-1:0] ns_add;
    logic [NS_W-1:0] ns_sub;

    // carry/borrow across the one-billion nanosecond boundary
    always_comb begin
        ns_sum = {1'b0, cur.ns} + {1'b0, delta.ns};
        carry  = (ns_sum >= {1'b0, NS_PER_SEC});
        ns_add = carry ? NS_W'(ns_sum - {1'b0, NS_PER_SEC}) : ns_sum[NS_W-1:0];
        borrow = (cur.ns < delta.ns);
        ns_sub = borrow ? cur.ns + NS_PER_SEC - delta.ns : cur.ns - delta.ns;
        nxt.fr = cur.fr;
        if (sub) begin
            nxt.ns  = ns_sub;
            nxt.sec = cur.sec - delta.sec - SEC_W'(borrow);
        end else begin
            nxt.ns  = ns_add;
            nxt.sec = cur.sec + delta.sec + SEC_W'(carry);
        end
    end
endmodule

// File: rtl/tod_capture_slots.sv
// Snapshot slots with valid flags. A capture fills the lowest empty slot,
// or the last slot when all are full; reading a slot's last word empties it.
// Assumes capture and read strobes are single-cycle.
module tod_capture_slots
    import tod_pkg::*;
#(
    parameter int SLOTS = N_SLOTS,
    localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_stb,
    input  tod_t              now,
    input  logic              rd_stb,
    input  logic [SW-1:0]     rd_slot,
    input  logic [2:0]        rd_word,
    output logic [SLOTS-1:0]  valid,
    output logic [WORD_W-1:0] word
);
    tod_t             snap_q [SLOTS];
    logic [SLOTS-1:0] valid_q;
    logic [SW-1:0]    tgt;
    tod_t             sel;

    // pick the lowest empty slot, else the last one
    always_comb begin
        tgt = SW'(SLOTS - 1);
        for (int i = SLOTS - 1; i >= 0; i--)
            if (!valid_q[i]) tgt = SW'(i);
    end

    // fill on capture, release on read of the last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < SLOTS; i++) snap_q[i] <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (cap_stb && tgt == SW'(i)) begin
                    snap_q[i]  <= now;
                    valid_q[i] <= 1'b1;
                end else if (rd_stb && rd_slot == SW'(i) && rd_word == LAST_WORD) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    // word select within the addressed slot
    always_comb begin
        sel = snap_q[rd_slot];
        case (rd_word)
            3'd0:    word = sel.sec[SEC_W-1:2*WORD_W];
            3'd1:    word = sel.sec[2*WORD_W-1:WORD_W];
            3'd2:    word = sel.sec[WORD_W-1:0];
            3'd3:    word = sel.ns[NS_W-1:WORD_W];
            3'd4:    word = sel.ns[WORD_W-1:0];
            3'd5:    word = sel.fr[FR_W-1:WORD_W];
            3'd6:    word = sel.fr[WORD_W-1:0];
            default: word = '0;
        endcase
    end

    assign valid = valid_q;

    // R9
    capture_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> valid_q != '0);
    // R9
    first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb && valid_q == '0) |=> valid_q[0]);
    // R10
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rd_word == LAST_WORD && !cap_stb) |=> !valid_q[$past(rd_slot)]);
endmodule

// File: rtl/tod_counter_unit.sv
// Time-of-day counter top: register file of 16-bit words, command decode,
// time register with step/adjust datapaths and two snapshot slots.
// Assumes software keeps staged nanoseconds below one billion.
module tod_counter_unit
    import tod_pkg::*;
#(
    parameter int DEF_STEP_NS = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic               run_q;
    logic [WORD_W-1:0]  cmd_q;
    logic [WORD_W-1:0]  step_ns_q;
    logic [FR_W-1:0]    step_fr_q;
    logic [FR_W-1:0]    trim_q;
    logic [WORD_W-1:0]  lv_q [LV_WORDS];
    tod_t               now_q, lv_tod, tick_nxt, adj_nxt;
    logic [2:0]         op;
    logic               cmd_go, cap_stb, slot_rd;
    logic [N_SLOTS-1:0] valid;
    logic [WORD_W-1:0]  slot_word, rd_mux, rdata_q;

    // command decode and load-value assembly
    assign op      = wdata[OP_LSB+2:OP_LSB];
    assign cmd_go  = wr_en && addr == A_CMD && wdata[TRIG_BIT];
    assign cap_stb = cmd_go && op == OP_CAPT;
    assign slot_rd = rd_en && addr[SLOT_BIT];
    assign lv_tod.sec = {lv_q[0], lv_q[1], lv_q[2]};
    assign lv_tod.ns  = {lv_q[3], lv_q[4]};
    assign lv_tod.fr  = {lv_q[5], lv_q[6]};

    tod_step_adder u_step (
        .cur(now_q), .step_ns(step_ns_q), .step_fr(step_fr_q),
        .trim(trim_q), .nxt(tick_nxt)
    );

    tod_adjuster u_adj (
        .cur(now_q), .delta(lv_tod), .sub(op == OP_DEC), .nxt(adj_nxt)
    );

    tod_capture_slots #(.SLOTS(N_SLOTS)) u_slots (
        .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .now(now_q),
        .rd_stb(slot_rd), .rd_slot(addr[3]), .rd_word(addr[2:0]),
        .valid(valid), .word(slot_word)
    );

    // staged load-value words, one register per address
    for (genvar i = 0; i < LV_WORDS; i++) begin : g_lv
        // capture a write to this load-value word
        always_ff @(posedge clk) begin
            if (!rst_n)                                  lv_q[i] <= '0;
            else if (wr_en && addr == ADDR_W'(A_LV + i)) lv_q[i] <= wdata;
        end
    end

    // control, command, step and trim registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            cmd_q     <= WORD_W'({OP_NOP, 2'b00});
            step_ns_q <= WORD_W'(DEF_STEP_NS);
            step_fr_q <= '0;
            trim_q    <= '0;
        end else begin
            if (wr_en && addr == A_CTRL)   run_q <= wdata[0];
            if (wr_en && addr == A_STP_NS) step_ns_q <= wdata;
            if (wr_en && addr == A_STP_FH) step_fr_q[FR_W-1:WORD_W] <= wdata;
            if (wr_en && addr == A_STP_FL) step_fr_q[WORD_W-1:0] <= wdata;
            if (wr_en && addr == A_CMD)
                cmd_q <= (cmd_go && op == OP_LOAD) ? (wdata & ~(WORD_W'(1) << PHASE_BIT)) : wdata;
            if (cmd_go && op == OP_FREQ)   trim_q <= lv_tod.fr;
        end
    end

    // time register: load and adjust take precedence over the tick
    always_ff @(posedge clk) begin
        if (!rst_n)                                      now_q <= '0;
        else if (cmd_go && op == OP_LOAD)                now_q <= lv_tod;
        else if (cmd_go && (op == OP_INC || op == OP_DEC)) now_q <= adj_nxt;
        else if (run_q)                                  now_q <= tick_nxt;
    end

    // read data select
    always_comb begin
        rd_mux = '0;
        if (addr[SLOT_BIT]) rd_mux = slot_word;
        else begin
            case (addr)
                A_CTRL:   rd_mux = WORD_W'(run_q);
                A_CMD:    rd_mux = cmd_q;
                A_STAT:   rd_mux = WORD_W'(valid);
                A_STP_NS: rd_mux = step_ns_q;
                A_STP_FH: rd_mux = step_fr_q[FR_W-1:WORD_W];
                A_STP_FL: rd_mux = step_fr_q[WORD_W-1:0];
                default:  rd_mux = '0;
            endcase
            for (int i = 0; i < LV_WORDS; i++)
                if (addr == ADDR_W'(A_LV + i)) rd_mux = lv_q[i];
        end
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;

    // R2 R5 R11
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !(cmd_go && (op == OP_LOAD || op == OP_INC || op == OP_DEC)))
        |=> $stable(now_q));
    // R4
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !cmd_go && now_q.ns < NS_PER_SEC) |=> now_q.ns < NS_PER_SEC);
    // R6
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && op == OP_LOAD) |=> (now_q == $past(lv_tod) && !cmd_q[PHASE_BIT]));
    // R7
    trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && op == OP_FREQ) |=> trim_q == $past(lv_tod.fr));
endmodule

// File: tb/tod_counter_unit_tb_top.sv
`timescale 1ns/1ps
module tod_counter_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model of the time and settings
    logic [47:0] m_sec = '0;
    logic [31:0] m_ns = '0, m_fr = '0;
    logic [15:0] m_step_ns = 16'd3;
    logic [31:0] m_step_fr = '0, m_trim = '0, m_lv_fr = '0;
    logic [47:0] m_lv_sec = '0;
    logic [31:0] m_lv_ns = '0;

    localparam logic [31:0] BILLION = 32'd1_000_000_000;

    always #2.5 clk = ~clk;

    tod_counter_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic cmd(input logic [2:0] op);
        wr(5'h01, {11'b0, op, 2'b01});
        wr(5'h01, {11'b0, 3'd7, 2'b01});
    endtask

    task automatic set_lv(input logic [47:0] s, input logic [31:0] n, input logic [31:0] f);
        wr(5'h06, s[47:32]); wr(5'h07, s[31:16]); wr(5'h08, s[15:0]);
        wr(5'h09, n[31:16]); wr(5'h0A, n[15:0]);
        wr(5'h0B, f[31:16]); wr(5'h0C, f[15:0]);
        m_lv_sec = s; m_lv_ns = n; m_lv_fr = f;
    endtask

    // model of one tick per requirement R3/R4
    task automatic m_tick(input int n);
        for (int i = 0; i < n; i++) begin
            logic [63:0] acc;
            acc = {m_ns, m_fr} + {16'b0, m_step_ns, m_step_fr} + {{32{m_trim[31]}}, m_trim};
            m_fr = acc[31:0];
            if (acc[63:32] >= BILLION) begin
                m_ns = acc[63:32] - BILLION;
                m_sec = m_sec + 48'd1;
            end else m_ns = acc[63:32];
        end
    endtask

    task automatic run(input int n);
        wr(5'h00, 16'd1);
        repeat (n - 1) @(posedge clk);
        wr(5'h00, 16'd0);
        m_tick(n);
    endtask

    task automatic read_slot(input bit slot, output logic [47:0] s, output logic [31:0] n, output logic [31:0] f);
        logic [15:0] w [7];
        for (int i = 0; i < 7; i++) rd({1'b1, slot, 3'(i)}, w[i]);
        s = {w[0], w[1], w[2]}; n = {w[3], w[4]}; f = {w[5], w[6]};
    endtask

    task automatic check_time(input string req);
        logic [47:0] s; logic [31:0] n, f;
        cmd(3'd4);
        read_slot(1'b0, s, n, f);
        chk(s == m_sec, {req, " seconds"}, 64'(s), 64'(m_sec));
        chk(n == m_ns,  {req, " nanoseconds"}, 64'(n), 64'(m_ns));
        chk(f == m_fr,  {req, " fraction"}, 64'(f), 64'(m_fr));
    endtask

    task automatic load_time(input logic [47:0] s, input logic [31:0] n, input logic [31:0] f);
        set_lv(s, n, f);
        cmd(3'd0);
        m_sec = s; m_ns = n; m_fr = f;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [47:0] s; logic [31:0] n, f;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(5'h01, d); chk(d == 16'h001C, "R1 command reset", 64'(d), 64'h1C);
        rd(5'h02, d); chk(d == 16'h0000, "R1 status reset", 64'(d), 64'h0);
        rd(5'h03, d); chk(d == 16'd3, "R1 step ns reset", 64'(d), 64'd3);
        rd(5'h04, d); chk(d == 16'h0, "R1 step frac reset", 64'(d), 64'h0);
        rd(5'h00, d); chk(d == 16'h0, "R1 run reset", 64'(d), 64'h0);
        check_time("R1 R9 R10 reset time");

        // R2 frozen while run bit clear
        repeat (20) @(posedge clk);
        check_time("R2 frozen");

        // R6 load and phase bit
        wr(5'h01, 16'h011D);
        rd(5'h01, d); chk(d == 16'h011D, "R6 command readback", 64'(d), 64'h11D);
        set_lv({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF, $urandom % BILLION, $urandom);
        wr(5'h01, 16'h0101);
        m_sec = m_lv_sec; m_ns = m_lv_ns; m_fr = m_lv_fr;
        rd(5'h01, d); chk(d[8] == 1'b0, "R6 phase bit cleared on load", 64'(d), 64'h1);
        wr(5'h01, 16'h001D);
        check_time("R6 load");

        // R2 R3 default step
        run(17);
        check_time("R2 R3 default step");

        // R3 random fractional steps
        for (int k = 0; k < 6; k++) begin
            m_step_ns = 16'(1 + $urandom % 1000);
            m_step_fr = $urandom;
            wr(5'h03, m_step_ns); wr(5'h04, m_step_fr[31:16]); wr(5'h05, m_step_fr[15:0]);
            run(1 + $urandom % 300);
            check_time("R3 fractional step");
        end

        // R4 rollover into seconds
        m_step_ns = 16'd3; m_step_fr = '0;
        wr(5'h03, 16'd3); wr(5'h04, 16'd0); wr(5'h05, 16'd0);
        load_time(48'h0000_1234_5678, BILLION - 32'd5, 32'd0);
        run(2);
        check_time("R4 rollover");

        // R7 negative trim with half-ns step fraction
        m_step_fr = 32'h8000_0000;
        wr(5'h04, 16'h8000);
        set_lv(48'd0, 32'd0, 32'hC000_0000);
        cmd(3'd1); m_trim = 32'hC000_0000;
        load_time(48'd77, 32'd999_999_000, 32'hC000_0000);
        run(600);
        check_time("R7 trim");

        // R5 R11 no-effect writes
        set_lv(48'hAAAA, 32'd5, 32'h1234_5678);
        wr(5'h01, 16'h0000);
        wr(5'h01, {11'b0, 3'd5, 2'b01});
        wr(5'h01, {11'b0, 3'd6, 2'b01});
        wr(5'h01, {11'b0, 3'd7, 2'b01});
        rd(5'h02, d); chk(d == 16'h0, "R5 R11 no capture from codes", 64'(d), 64'h0);
        check_time("R5 R11 untriggered and unused codes");

        // R8 directed carry and borrow, then random adjusts
        load_time(48'd100, BILLION - 32'd10, 32'h5);
        set_lv(48'd1, 32'd10, 32'h0); cmd(3'd2);
        m_sec = 48'd102; m_ns = 32'd0;
        check_time("R8 increment carry");
        set_lv(48'd2, 32'd1, 32'h0); cmd(3'd3);
        m_sec = 48'd99; m_ns = BILLION - 32'd1;
        check_time("R8 decrement borrow");
        for (int k = 0; k < 12; k++) begin
            logic [31:0] dn;
            logic [47:0] ds;
            bit sub;
            dn = $urandom % BILLION; ds = 48'($urandom % 65536); sub = $urandom % 2;
            set_lv(ds, dn, $urandom);
            cmd(sub ? 3'd3 : 3'd2);
            if (sub) begin
                if (m_ns < dn) begin m_ns = m_ns + BILLION - dn; m_sec = m_sec - ds - 48'd1; end
                else begin m_ns = m_ns - dn; m_sec = m_sec - ds; end
            end else begin
                logic [32:0] t;
                t = {1'b0, m_ns} + {1'b0, dn};
                if (t >= {1'b0, BILLION}) begin m_ns = 32'(t - {1'b0, BILLION}); m_sec = m_sec + ds + 48'd1; end
                else begin m_ns = t[31:0]; m_sec = m_sec + ds; end
            end
            check_time("R8 random adjust");
        end

        // R9 R10 two slots and read order
        load_time(48'h1111, 32'd111, 32'h11);
        cmd(3'd4);
        load_time(48'h2222, 32'd222, 32'h22);
        cmd(3'd4);
        rd(5'h02, d); chk(d == 16'h3, "R9 both slots valid", 64'(d), 64'h3);
        read_slot(1'b1, s, n, f);
        chk(s == 48'h2222 && n == 32'd222 && f == 32'h22, "R9 slot 1 holds second capture", 64'(n), 64'd222);
        rd(5'h02, d); chk(d == 16'h1, "R10 slot 1 released", 64'(d), 64'h1);
        read_slot(1'b0, s, n, f);
        chk(s == 48'h1111 && n == 32'd111 && f == 32'h11, "R9 slot 0 holds first capture", 64'(n), 64'd111);
        rd(5'h02, d); chk(d == 16'h0, "R10 slot 0 released", 64'(d), 64'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule